// File: doc/BRIEF.md
# Pause Flow Control Resolver

This block settles which pause directions a MAC uses once a link is up. It combines the local and link-partner pause advertisements, the mode requested by software, the state of autonegotiation and the negotiated duplex into one 2-bit mode. From that mode it drives a transmit-pause enable and a receive-pause enable. It also gates the receive-buffer threshold values, which only matter while this end may send pause frames.

Resolution is requested by a single-cycle strobe, and every output is registered. When autonegotiation is switched off, the requested mode is applied as it stands. When autonegotiation is switched on, the advertisement bits decide the mode, with two overrides: a symmetric result is cut back to receive-only unless full was requested, and a half-duplex link yields no pause at all. If a strobe arrives while autonegotiation is enabled but not yet finished, the outputs keep their old values.

Top module: `pfcResolver`

## Requirements
- R1: After reset, the mode is 0 (none), both enables are 0, and both threshold outputs are 0.
- R2: The mode encoding is 0 none, 1 receive-only, 2 transmit-only, 3 full. The receive enable equals mode bit 0 and the transmit enable equals mode bit 1.
- R3: With autonegotiation enabled and complete on a full-duplex link, if both the local and the partner pause bits are 1, the mode is full when the effective request is full. Otherwise the mode is receive-only.
- R4: Under the same conditions, local pause 0 / asymmetric 1 with partner pause 1 / asymmetric 1 gives transmit-only.
- R5: Under the same conditions, local pause 1 / asymmetric 1 with partner pause 0 / asymmetric 1 gives receive-only.
- R6: Under the same conditions, every other advertisement combination gives none.
- R7: With autonegotiation enabled and complete, a half-duplex link gives none, whatever the advertisement bits are.
- R8: A strobe that arrives while autonegotiation is enabled but not complete leaves every output unchanged.
- R9: With autonegotiation disabled, the mode is the requested mode. The request is 3 bits: values 0 to 3 are the modes listed in R2, and any value of 4 or more means "default", which is treated as full.
- R10: When the resolved mode has its transmit bit set, the high threshold output equals the high input. The low threshold output then carries the low input in bits [WM_WIDTH-1:0] and the XON-send request in bit WM_WIDTH. Otherwise both threshold outputs are 0.
- R11: Outputs change only on the clock edge that samples a strobe, so they are valid in the following cycle. Input changes made without a strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resolveStb | input | 1 | Request a resolution this cycle |
| anEnable | input | 1 | Autonegotiation enabled |
| anDone | input | 1 | Autonegotiation complete |
| fullDuplex | input | 1 | Negotiated duplex, 1 for full |
| locPause | input | 1 | Local symmetric pause advertisement |
| locAsym | input | 1 | Local asymmetric direction advertisement |
| lpPause | input | 1 | Partner symmetric pause advertisement |
| lpAsym | input | 1 | Partner asymmetric direction advertisement |
| reqMode | input | 3 | Requested mode (4 and above mean default) |
| sendXon | input | 1 | Request XON frame sending |
| lowWater | input | WM_WIDTH | Low threshold value |
| highWater | input | WM_WIDTH | High threshold value |
| fcMode | output | 2 | Resolved mode |
| txPauseEn | output | 1 | Transmit pause enable |
| rxPauseEn | output | 1 | Receive pause enable |
| lowMark | output | WM_WIDTH+1 | Gated low threshold, with the XON enable in the top bit |
| highMark | output | WM_WIDTH | Gated high threshold |

## Verification
The assertions assume that the strobe is only a request and that every other input may change in any cycle. They also assume that reset is held for at least one clock edge before the first strobe. The stimulus drives all inputs, strobe included, half a period away from the sampling edge. It lowers the strobe before the next edge, so each request is seen exactly once. Between strobes, the bench changes the advertisement, duplex and threshold inputs to show that they are ignored without a strobe.

// File: rtl/pfcPkg.sv
package pfcPkg;
  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_RX   = 2'd1,
    FC_TX   = 2'd2,
    FC_FULL = 2'd3
  } fcMode_e;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic load;    // capture a new result this edge
    logic useNeg;  // resolve from advertisements rather than the request
  } fcCtl_t;
endpackage

// File: rtl/pfcControl.sv
module pfcControl
  import pfcPkg::*;
(
  input  logic   resolveStb,
  input  logic   anEnable,
  input  logic   anDone,
  output fcCtl_t ctl
);
  logic negPending;

  always_comb begin
    negPending = anEnable && !anDone;
    ctl.load   = resolveStb && !negPending;
    ctl.useNeg = anEnable;
  end
endmodule

// File: rtl/pfcDatapath.sv
module pfcDatapath
  import pfcPkg::*;
#(
  parameter int WM_WIDTH = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  fcCtl_t              ctl,
  input  logic                fullDuplex,
  input  logic                locPause,
  input  logic                locAsym,
  input  logic                lpPause,
  input  logic                lpAsym,
  input  logic [2:0]          reqMode,
  input  logic                sendXon,
  input  logic [WM_WIDTH-1:0] lowWater,
  input  logic [WM_WIDTH-1:0] highWater,
  output logic [1:0]          fcMode,
  output logic                txPauseEn,
  output logic                rxPauseEn,
  output logic [WM_WIDTH:0]   lowMark,
  output logic [WM_WIDTH-1:0] highMark
);
  localparam int LOW_W = WM_WIDTH + 1;

  fcMode_e effReq;
  fcMode_e negMode;
  fcMode_e nextMode;
  logic    nextTx;
  logic    nextRx;

  always_comb begin
    effReq = reqMode[2] ? FC_FULL : fcMode_e'(reqMode[1:0]);

    if (locPause && lpPause)
      negMode = (effReq == FC_FULL) ? FC_FULL : FC_RX;
    else if (!locPause && locAsym && lpPause && lpAsym)
      negMode = FC_TX;
    else if (locPause && locAsym && !lpPause && lpAsym)
      negMode = FC_RX;
    else
      negMode = FC_NONE;

    if (!ctl.useNeg)
      nextMode = effReq;
    else if (!fullDuplex)
      nextMode = FC_NONE;
    else
      nextMode = negMode;

    nextTx = (nextMode == FC_TX) || (nextMode == FC_FULL);
    nextRx = (nextMode == FC_RX) || (nextMode == FC_FULL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fcMode    <= FC_NONE;
      txPauseEn <= 1'b0;
      rxPauseEn <= 1'b0;
      lowMark   <= '0;
      highMark  <= '0;
    end else if (ctl.load) begin
      fcMode    <= nextMode;
      txPauseEn <= nextTx;
      rxPauseEn <= nextRx;
      if (nextTx) begin
        lowMark  <= LOW_W'({sendXon, lowWater});
        highMark <= highWater;
      end else begin
        lowMark  <= '0;
        highMark <= '0;
      end
    end
  end
endmodule

// File: rtl/pfcResolver.sv
module pfcResolver
  import pfcPkg::*;
#(
  parameter int WM_WIDTH = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                resolveStb,
  input  logic                anEnable,
  input  logic                anDone,
  input  logic                fullDuplex,
  input  logic                locPause,
  input  logic                locAsym,
  input  logic                lpPause,
  input  logic                lpAsym,
  input  logic [2:0]          reqMode,
  input  logic                sendXon,
  input  logic [WM_WIDTH-1:0] lowWater,
  input  logic [WM_WIDTH-1:0] highWater,
  output logic [1:0]          fcMode,
  output logic                txPauseEn,
  output logic                rxPauseEn,
  output logic [WM_WIDTH:0]   lowMark,
  output logic [WM_WIDTH-1:0] highMark
);
  fcCtl_t ctl;

  pfcControl uCtl (
    .resolveStb(resolveStb),
    .anEnable  (anEnable),
    .anDone    (anDone),
    .ctl       (ctl)
  );

  pfcDatapath #(.WM_WIDTH(WM_WIDTH)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .fullDuplex(fullDuplex),
    .locPause  (locPause),
    .locAsym   (locAsym),
    .lpPause   (lpPause),
    .lpAsym    (lpAsym),
    .reqMode   (reqMode),
    .sendXon   (sendXon),
    .lowWater  (lowWater),
    .highWater (highWater),
    .fcMode    (fcMode),
    .txPauseEn (txPauseEn),
    .rxPauseEn (rxPauseEn),
    .lowMark   (lowMark),
    .highMark  (highMark)
  );
endmodule

// File: rtl/pfcResolverChecker.sv
module pfcResolverChecker #(
  parameter int WM_WIDTH = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                resolveStb,
  input logic                anEnable,
  input logic                anDone,
  input logic                fullDuplex,
  input logic [1:0]          fcMode,
  input logic                txPauseEn,
  input logic                rxPauseEn,
  input logic [WM_WIDTH:0]   lowMark,
  input logic [WM_WIDTH-1:0] highMark
);
  // R2: the two enables follow the bits of the registered mode
  assert_enable_map_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txPauseEn == fcMode[1]) && (rxPauseEn == fcMode[0]));

  // R7: a completed negotiation on a half-duplex link gives none
  assert_half_duplex_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resolveStb && anEnable && anDone && !fullDuplex) |=> (fcMode == 2'd0));

  // R8: a strobe during an unfinished negotiation holds the outputs
  assert_hold_pending_R8: assert property (@(posedge clk) disable iff (!rstN)
    (resolveStb && anEnable && !anDone) |=>
      ($stable(fcMode) && $stable(lowMark) && $stable(highMark)));

  // R10: with no transmit pause, both thresholds are zero
  assert_gate_marks_R10: assert property (@(posedge clk) disable iff (!rstN)
    !txPauseEn |-> ((lowMark == '0) && (highMark == '0)));

  // R11: without a strobe nothing moves
  assert_no_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    !resolveStb |=> ($stable(fcMode) && $stable(txPauseEn) &&
                     $stable(rxPauseEn) && $stable(highMark)));
endmodule

bind pfcResolver pfcResolverChecker #(.WM_WIDTH(WM_WIDTH)) uChk (.*);

// File: tb/pfcResolver_test.sv
`timescale 1ns/1ps
module pfcResolver_test;
  localparam int WM = 16;

  typedef struct {
    logic [1:0]    mode;
    logic          tx;
    logic          rx;
    logic [WM:0]   lo;
    logic [WM-1:0] hi;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resolveStb = 1'b0, anEnable = 1'b0, anDone = 1'b0, fullDuplex = 1'b1;
  logic locPause = 1'b0, locAsym = 1'b0, lpPause = 1'b0, lpAsym = 1'b0;
  logic [2:0] reqMode = 3'd0;
  logic sendXon = 1'b0;
  logic [WM-1:0] lowWater = '0, highWater = '0;
  logic [1:0] fcMode;
  logic txPauseEn, rxPauseEn;
  logic [WM:0] lowMark;
  logic [WM-1:0] highMark;

  int checks = 0;
  int fails = 0;
  exp_t q[$];
  exp_t last;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfcResolver #(.WM_WIDTH(WM)) uut (.*);

  // Model of the requirements
  function automatic exp_t model(string tag);
    exp_t e;
    logic [1:0] req;
    logic [1:0] m;
    req = reqMode[2] ? 2'd3 : reqMode[1:0];
    if (anEnable && !anDone) begin
      e = last;
      e.tag = tag;
      return e;
    end
    if (!anEnable) m = req;
    else if (!fullDuplex) m = 2'd0;
    else if (locPause && lpPause) m = (req == 2'd3) ? 2'd3 : 2'd1;
    else if (!locPause && locAsym && lpPause && lpAsym) m = 2'd2;
    else if (locPause && locAsym && !lpPause && lpAsym) m = 2'd1;
    else m = 2'd0;
    e.mode = m;
    e.tx = m[1];
    e.rx = m[0];
    e.lo = m[1] ? {sendXon, lowWater} : '0;
    e.hi = m[1] ? highWater : '0;
    e.tag = tag;
    return e;
  endfunction

  task automatic resolve(input logic en, input logic dn, input logic fd,
                         input logic [3:0] adv, input logic [2:0] rq,
                         input string tag);
    exp_t e;
    @(negedge clk);
    anEnable = en; anDone = dn; fullDuplex = fd;
    {locPause, locAsym, lpPause, lpAsym} = adv;
    reqMode = rq;
    resolveStb = 1'b1;
    e = model(tag);
    @(negedge clk);
    resolveStb = 1'b0;
    last = e;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic cmp(input exp_t e);
    checks++;
    if (fcMode !== e.mode || txPauseEn !== e.tx || rxPauseEn !== e.rx ||
        lowMark !== e.lo || highMark !== e.hi) begin
      fails++;
      $display("FAIL %s: got mode=%0d tx=%0b rx=%0b lo=%h hi=%h exp mode=%0d tx=%0b rx=%0b lo=%h hi=%h",
               e.tag, fcMode, txPauseEn, rxPauseEn, lowMark, highMark,
               e.mode, e.tx, e.rx, e.lo, e.hi);
    end
  endtask

  // Monitor: compares each expected item once the design result is settled
  initial begin
    forever begin
      wait (q.size() > 0);
      #1;
      cmp(q.pop_front());
    end
  end

  initial begin
    exp_t e;
    lowWater = 16'h1234; highWater = 16'hABCD; sendXon = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    e.mode = 0; e.tx = 0; e.rx = 0; e.lo = '0; e.hi = '0; e.tag = "R1 reset";
    last = e;
    q.push_back(e); wait (q.size() == 0);
    @(negedge clk); rstN = 1'b1;

    // R3: both pause bits, request full and default, then rx-only/none requests
    resolve(1, 1, 1, 4'b1010, 3'd3, "R3 sym req full");
    resolve(1, 1, 1, 4'b1111, 3'd4, "R3 sym req default");
    resolve(1, 1, 1, 4'b1010, 3'd1, "R3 sym req rx downgrade");
    resolve(1, 1, 1, 4'b1110, 3'd0, "R3 sym req none");
    // R4 / R5
    resolve(1, 1, 1, 4'b0111, 3'd3, "R4 tx only");
    resolve(1, 1, 1, 4'b1101, 3'd3, "R5 rx only");
    // R6: other combinations
    for (int a = 0; a < 16; a++) begin
      if (a[3] && a[1]) continue;
      if (a == 4'b0111 || a == 4'b1101) continue;
      resolve(1, 1, 1, 4'(a), 3'd3, "R6 other combo");
    end
    // R7: half duplex
    resolve(1, 1, 1, 4'b0111, 3'd3, "R7 pre tx");
    resolve(1, 1, 0, 4'b0111, 3'd3, "R7 half duplex");
    resolve(1, 1, 0, 4'b1111, 3'd3, "R7 half duplex sym");
    // R8: pending negotiation holds
    resolve(1, 1, 1, 4'b1111, 3'd3, "R8 pre full");
    resolve(1, 0, 0, 4'b0000, 3'd0, "R8 hold while pending");
    // R9: forced modes
    resolve(0, 0, 0, 4'b0000, 3'd1, "R9 forced rx");
    resolve(0, 0, 1, 4'b0000, 3'd2, "R9 forced tx");
    resolve(0, 0, 1, 4'b0000, 3'd7, "R9 forced default");
    resolve(0, 0, 1, 4'b1111, 3'd0, "R9 forced none");
    // R10: XON bit off, new thresholds
    sendXon = 1'b0; lowWater = 16'h0F0F; highWater = 16'h7777;
    resolve(0, 0, 1, 4'b0000, 3'd2, "R10 marks without xon");
    resolve(0, 0, 1, 4'b0000, 3'd1, "R10 marks zero rx");
    // R11: inputs change without a strobe
    resolve(0, 0, 1, 4'b0000, 3'd3, "R11 pre full");
    @(negedge clk);
    reqMode = 3'd0; anEnable = 1'b1; anDone = 1'b1; fullDuplex = 1'b0;
    highWater = 16'h0001; lowWater = 16'h0002; sendXon = 1'b1;
    repeat (3) @(negedge clk);
    e = last; e.tag = "R11 no strobe ignored";
    q.push_back(e); wait (q.size() == 0);
    // R2 covered by every enable comparison above
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    #10;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule